// File: doc/BRIEF.md
# Bit-Serial Signed Multiply-Accumulate Neuron

This block is one processing element of a layer-multiplexed neural array. Each multiply takes one frame of 2N+2 enabled clock cycles. A parallel N-bit two's-complement weight is held against an N-bit two's-complement activation. The activation arrives on a single wire, least significant bit first, one bit in each of the first N enabled cycles of the frame. The multiplier is a cascade of N+1 AND/XOR cells. In the frame's sign cycle, a sequencer inverts every cell output and injects a carry, which subtracts the sign-weighted term. The product therefore leaves the multiplier as a sign-extended (2N+2)-bit serial stream, least significant bit first. The first product bit appears in the first cycle of the frame.

A single full adder folds that stream into a circular chain of 2N+2 flip-flops. The chain completes one revolution per frame, so when a frame ends the running dot product sits in the chain in natural bit order. Frames may follow each other with no gap. The controller can pause a frame at any cycle by dropping the enable. A clear input empties the chain and restarts the frame count, and is used at the start of each neuron's dot product. When the select input is high, the chain contents drive a shared result bus. When it is low, the bus driver is released.

Top module: `mac_neuron`

## Requirements
- R1: After reset, with select high, the result bus reads zero.
- R2: A frame is exactly 2N+2 enabled cycles (34 for N=16). The frame counter wraps to 0 after its last cycle, and the accumulated sum is readable in parallel once a frame has completed.
- R3: Each frame adds the exact signed product of weight and activation, both N-bit two's complement, including (-2^(N-1)) x (-2^(N-1)) = 2^(2N-2).
- R4: Successive frames without a clear accumulate their products modulo 2^(2N+2). The bus bits read as a two's-complement sum, with bit 0 as the LSB.
- R5: While the enable is low, the frame position, the product state and the accumulated sum do not change, so stall cycles inserted anywhere in a frame leave the result unchanged.
- R6: A clear (which has priority over the enable) zeroes the accumulated sum and returns the frame counter to its first cycle, abandoning any partial frame.
- R7: Values on the serial activation input during frame cycles N through 2N+1 have no effect on the result.
- R8: With select high, the bus carries the accumulated sum. With select low, the block does not drive the bus, and another driver's value is seen unaltered.
- R9: The weight is sampled in the first enabled cycle of a frame, and later changes to the weight input within that frame have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of sum and frame position |
| en_i | input | 1 | Advance the frame by one cycle |
| act_i | input | 1 | Serial activation bit, LSB first |
| wgt_i | input | N (16) | Parallel signed weight |
| oe_i | input | 1 | Result bus select |
| sum_o | output | 2N+2 (34) | Tri-state accumulated sum |

## Verification
Any fault in the frame counter, the sign-cycle correction or the carry clearing corrupts the sum seen on the bus at the first frame boundary after the fault. A mistimed sign cycle shows up only with negative activations, so the bench mixes signs and uses the most negative value in both operands. A carry leaking across frames shows up only when frames run back to back without a clear. An ignored stall or an unlatched weight stays hidden until the bench inserts stalls or changes the weight mid-frame, and the comparison after that same frame then exposes it.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // Role of the current cycle inside a multiply frame.
  typedef enum logic [1:0] {
    PH_MAG  = 2'd0,  // add activation bit times weight
    PH_SIGN = 2'd1,  // subtract: activation sign bit times weight
    PH_TAIL = 2'd2   // no new term, drain upper product bits
  } mac_phase_e;
endpackage

// File: rtl/mac_seq.sv
module mac_seq #(
  parameter int N = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          en_i,
  output logic [$clog2(2*N+2)-1:0]      cnt_o,
  output logic                          first_o,
  output logic                          step_o,
  output mac_pkg::mac_phase_e           phase_o
);
  import mac_pkg::*;
  localparam int F  = 2 * N + 2;
  localparam int CW = $clog2(F);
  localparam logic [CW-1:0] LAST    = CW'(F - 1);
  localparam logic [CW-1:0] SIGN_AT = CW'(N - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    if (cnt_q < SIGN_AT)       phase_o = PH_MAG;
    else if (cnt_q == SIGN_AT) phase_o = PH_SIGN;
    else                       phase_o = PH_TAIL;
  end

  assign cnt_o   = cnt_q;
  assign first_o = (cnt_q == '0);
  assign step_o  = en_i & ~clr_i;
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int N = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  input  logic                first_i,
  input  mac_pkg::mac_phase_e phase_i,
  input  logic                act_i,
  input  logic [N-1:0]        wgt_i,
  output logic                pbit_o,
  output logic [N:0]          rem_o
);
  import mac_pkg::*;

  logic [N-1:0] wgt_q;
  logic [N-1:0] y;
  logic [N:0]   ysx, term, pp_q, pp_d, pp_in;
  logic [N+1:0] sum;
  logic         inv, xg;

  assign y     = first_i ? wgt_i : wgt_q;
  assign ysx   = {y[N-1], y};
  assign inv   = (phase_i == PH_SIGN);
  assign xg    = act_i & (phase_i != PH_TAIL);
  assign pp_in = first_i ? '0 : pp_q;

  // One AND/XOR cell per weight bit (plus the sign extension bit).
  for (genvar i = 0; i <= N; i++) begin : g_cell
    assign term[i] = (xg & ysx[i]) ^ inv;
  end

  assign sum    = {pp_in[N], pp_in} + {term[N], term} + {{(N+1){1'b0}}, inv};
  assign pbit_o = sum[0];
  assign pp_d   = step_i ? sum[N+1:1] : pp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp_q  <= '0;
      wgt_q <= '0;
    end else begin
      pp_q <= pp_d;
      if (step_i && first_i) wgt_q <= wgt_i;
    end
  end

  assign rem_o = pp_q;
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int F = 34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic         first_i,
  input  logic         pbit_i,
  output logic [F-1:0] chain_o
);
  logic [F-1:0] chain_q, chain_d;
  logic         carry_q, carry_d, cin, s;

  assign cin = first_i ? 1'b0 : carry_q;
  assign s   = chain_q[0] ^ pbit_i ^ cin;

  always_comb begin
    chain_d = chain_q;
    carry_d = carry_q;
    if (clr_i) begin
      chain_d = '0;
      carry_d = 1'b0;
    end else if (step_i) begin
      chain_d = {s, chain_q[F-1:1]};
      carry_d = (chain_q[0] & pbit_i) | (chain_q[0] & cin) | (pbit_i & cin);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      carry_q <= 1'b0;
    end else begin
      chain_q <= chain_d;
      carry_q <= carry_d;
    end
  end

  assign chain_o = chain_q;
endmodule

// File: rtl/mac_neuron.sv
module mac_neuron #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic                 act_i,
  input  logic [N-1:0]         wgt_i,
  input  logic                 oe_i,
  output wire  [2*N+1:0]       sum_o
);
  import mac_pkg::*;
  localparam int F  = 2 * N + 2;
  localparam int CW = $clog2(F);

  logic [CW-1:0] seq_cnt;
  logic          first, step, pbit;
  mac_phase_e    phase;
  logic [N:0]    mul_rem;
  logic [F-1:0]  acc_chain;

  mac_seq #(.N(N)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .en_i(en_i),
    .cnt_o(seq_cnt), .first_o(first), .step_o(step), .phase_o(phase)
  );

  mac_mult #(.N(N)) u_mult (
    .clk(clk), .rst_n(rst_n), .step_i(step), .first_i(first),
    .phase_i(phase), .act_i(act_i), .wgt_i(wgt_i),
    .pbit_o(pbit), .rem_o(mul_rem)
  );

  mac_accum #(.F(F)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .step_i(step),
    .first_i(first), .pbit_i(pbit), .chain_o(acc_chain)
  );

  assign sum_o = oe_i ? acc_chain : {F{1'bz}};
endmodule

// File: rtl/mac_neuron_chk.sv
module mac_neuron_chk #(
  parameter int N = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clr_i,
  input logic                     en_i,
  input logic [$clog2(2*N+2)-1:0] cnt,
  input logic [2*N+1:0]           chain,
  input logic [N:0]               rem
);
  localparam int F  = 2 * N + 2;
  localparam int CW = $clog2(F);

  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (chain == '0 && cnt == '0));

  assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> ($stable(chain) && $stable(cnt) && $stable(rem)));

  assert_frame_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && cnt == CW'(F - 1)) |=> (cnt == '0));

  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(F - 1));

  assert_tail_is_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(F - 1)) |-> ($countones(rem) == 0 || $countones(rem) == N + 1));
endmodule

bind mac_neuron mac_neuron_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .en_i(en_i),
  .cnt(seq_cnt), .chain(acc_chain), .rem(mul_rem)
);

// File: tb/mac_neuron_tb.sv
module mac_neuron_tb;
  localparam int N = 16;
  localparam int F = 2 * N + 2;

  typedef struct {
    logic [F-1:0] val;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, clr, en, act, oe, tb_drv;
  logic [N-1:0] wgt;
  logic [F-1:0] tb_val;
  wire  [F-1:0] bus;

  exp_t         exp_q[$];
  logic [F-1:0] model;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign bus = tb_drv ? tb_val : {F{1'bz}};

  mac_neuron #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(en), .act_i(act),
    .wgt_i(wgt), .oe_i(oe), .sum_o(bus)
  );

  // Monitor: pops expected items and compares with the bus.
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      @(negedge clk);
      compared++;
      if (bus !== exp_q[0].val) begin
        mismatched++;
        $display("FAIL %s: bus=%h expected=%h", exp_q[0].tag, bus, exp_q[0].val);
      end
      void'(exp_q.pop_front());
    end
  end

  task automatic expect_sum(input string tag);
    exp_t e;
    oe = 1'b1;
    e.val = model;
    e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
    oe = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1; en = 1'b1;
    @(negedge clk);
    clr = 1'b0; en = 1'b0;
    model = '0;
  endtask

  // One frame; optional stalls, junk tail bits and mid-frame weight changes.
  task automatic do_frame(input logic signed [N-1:0] w, input logic signed [N-1:0] x,
                          input bit stalls, input bit junk, input bit wchg);
    longint p;
    for (int k = 0; k < F; k++) begin
      if (stalls && ($urandom_range(0, 2) == 0)) begin
        en = 1'b0; act = 1'($urandom); wgt = 16'($urandom);
        @(negedge clk);
      end
      en  = 1'b1;
      wgt = (k == 0 || !wchg) ? w : 16'($urandom);
      act = (k < N) ? x[k] : (junk ? 1'($urandom) : x[N-1]);
      @(negedge clk);
    end
    en = 1'b0;
    p = longint'(w) * longint'(x);
    model = model + p[F-1:0];
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0; en = 1'b0; act = 1'b0; oe = 1'b0;
    tb_drv = 1'b0; tb_val = '0; wgt = '0; model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    expect_sum("R1 reset sum");

    do_frame(16'sd3, 16'sd5, 0, 0, 0);
    expect_sum("R2 single frame");

    do_clear();
    do_frame(-16'sd32768, -16'sd32768, 0, 0, 0);
    expect_sum("R3 most negative squared");

    do_clear();
    do_frame(-16'sd32768, 16'sd32767, 0, 0, 0);
    expect_sum("R3 min times max");

    do_clear();
    do_frame(16'sd1234, -16'sd1, 0, 0, 0);
    expect_sum("R3 negative activation");

    do_clear();
    for (int i = 0; i < 20; i++) begin
      do_frame(16'($urandom), 16'($urandom), 0, 0, 0);
      if (i % 5 == 4) expect_sum("R4 back-to-back accumulate");
    end

    do_clear();
    for (int i = 0; i < 9; i++) do_frame(-16'sd32768, -16'sd32768, 0, 0, 0);
    expect_sum("R4 wrap modulo");

    do_clear();
    for (int i = 0; i < 6; i++) do_frame(16'($urandom), 16'($urandom), 1, 0, 0);
    expect_sum("R5 stalls mid-frame");

    do_clear();
    for (int i = 0; i < 6; i++) do_frame(16'($urandom), 16'($urandom), 0, 1, 0);
    expect_sum("R7 tail activation ignored");

    do_clear();
    for (int i = 0; i < 6; i++) do_frame(16'($urandom), 16'($urandom), 0, 0, 1);
    expect_sum("R9 weight latched at frame start");

    do_frame(16'sd700, -16'sd9, 0, 0, 0);
    for (int k = 0; k < 11; k++) begin
      en = 1'b1; act = 1'($urandom); wgt = 16'($urandom);
      @(negedge clk);
    end
    en = 1'b0;
    do_clear();
    expect_sum("R6 clear mid-frame");
    do_frame(-16'sd77, 16'sd301, 0, 0, 0);
    expect_sum("R6 frame after clear");

    oe = 1'b0; tb_drv = 1'b1; tb_val = 34'h2_A5A5_3C3C;
    begin
      exp_t e;
      e.val = tb_val;
      e.tag = "R8 driver released";
      exp_q.push_back(e);
      wait (exp_q.size() == 0);
    end
    tb_drv = 1'b0;
    expect_sum("R8 driven when selected");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: bus=%h expected=finish", bus);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule